// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The controller gathers eight peripheral request lines and hands a processor one interrupt line plus the 3-bit number of the source that should be served next. Request lines are level-sensitive and sampled on the clock. A set line marks its source pending in a request register, and a per-source mask removes pending sources from arbitration. The processor picks the priority scheme at run time through a control word. In the nested scheme source 0 always ranks first and source 7 last. In the rotating scheme the source that most recently finished service drops to the bottom of the order and the rest move up.

The processor services an interrupt in two steps. An acknowledge pulse latches the winner's number onto the vector output, marks that source in service and clears its pending bit. An end-of-service pulse later retires the highest-ranked in-service source. While a source is in service, only a source that ranks strictly above every in-service source raises the interrupt again. This lets service routines nest.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_out is 0, vec_out is 0, all sources are unmasked, and the nested scheme is selected with source 0 ranked highest.
- R2: A request line sampled high at a clock edge makes its source pending from that edge. The source stays pending after the line drops, until it is acknowledged. irq_out can rise in the cycle after the edge that samples the line.
- R3: In the nested scheme, with nothing in service, the pending unmasked source with the lowest number wins.
- R4: An acknowledge while irq_out is 1 loads the winner's number into vec_out at that edge, marks it in service and clears its pending bit, unless its line is still high and sets the bit again.
- R5: irq_out is 1 only when the winning pending source ranks strictly above every in-service source.
- R6: Writing cfg_wdata to the mask register (cfg_sel=1) inhibits each source whose bit is 1. A masked source never drives irq_out but stays pending, and it wins once its mask bit is cleared.
- R7: Writing the control word (cfg_sel=0) with bit 0 set selects the rotating scheme, and with bit 0 clear selects the nested scheme.
- R8: In the rotating scheme, an end of service makes the retired source the lowest-ranked one, and the source numbered one above it (wrapping from 7 to 0) becomes the highest.
- R9: An end of service clears the highest-ranked in-service source only. With nothing in service it changes nothing.
- R10: An acknowledge while irq_out is 0 changes neither vec_out nor any pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Request lines, bit n is source n |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = mask register |
| cfg_wdata | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge pulse |
| eos | input | 1 | End-of-service pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 3 | Number of the last acknowledged source |

## Verification
Directed sequences cover four areas:
- Simultaneous requests check nested order.
- A lower request arriving during service, followed by a higher one, separates "no preemption" from "strict preemption".
- A masked request followed by an unmask shows that pending state survives masking.
- A series of retirements in rotating mode shows the ranking pointer moving to the retired source rather than staying fixed.

Constrained random traffic then mixes sparse request bursts, acknowledges, end-of-service pulses and occasional mode and mask writes. This exercises overlapping nesting in both schemes against a bench model of the ranking rules.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    SCHEME_NESTED = 1'b0,
    SCHEME_ROTATE = 1'b1
  } scheme_e;
endpackage

// File: rtl/prio_pick.sv
// Circular first-one finder: rank 0 is the source at position base.
module prio_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] base,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [W-1:0] rank
);
  always_comb begin
    any  = 1'b0;
    rank = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[(int'(base) + i) % N]) begin
        any  = 1'b1;
        rank = W'(i);
      end
    end
    idx = W'((int'(base) + int'(rank)) % N);
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         sel,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output scheme_e      scheme_q
);
  logic [N-1:0] mask_n;
  scheme_e      scheme_n;

  always_comb begin
    mask_n   = mask_q;
    scheme_n = scheme_q;
    if (we) begin
      if (sel) mask_n   = wdata;
      else     scheme_n = wdata[0] ? SCHEME_ROTATE : SCHEME_NESTED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      scheme_q <= SCHEME_NESTED;
    end else if (we) begin
      mask_q   <= mask_n;
      scheme_q <= scheme_n;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [NSRC-1:0] cfg_wdata,
  input  logic            ack,
  input  logic            eos,
  output logic            irq_out,
  output logic [IDW-1:0]  vec_out
);
  logic [NSRC-1:0] req_q, req_n, isr_q, isr_n, mask_q, cand;
  logic [IDW-1:0]  lp_q, lp_n, vec_q, vec_n, base;
  scheme_e         scheme_q;
  logic            win_any, isr_any, do_ack, do_eos;
  logic [IDW-1:0]  win_idx, win_rank, top_idx, top_rank;
  logic [NSRC-1:0] win_hot, top_hot;

  irq_cfg_regs #(.N(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .mask_q(mask_q), .scheme_q(scheme_q)
  );

  // highest rank sits one above the lowest-priority pointer when rotating
  assign base = (scheme_q == SCHEME_ROTATE) ?
                IDW'((int'(lp_q) + 1) % NSRC) : '0;
  assign cand = req_q & ~mask_q;

  prio_pick #(.N(NSRC), .W(IDW)) u_pick_req (
    .vec(cand), .base(base), .any(win_any), .idx(win_idx), .rank(win_rank)
  );
  prio_pick #(.N(NSRC), .W(IDW)) u_pick_isr (
    .vec(isr_q), .base(base), .any(isr_any), .idx(top_idx), .rank(top_rank)
  );

  assign irq_out = win_any && (!isr_any || (win_rank < top_rank));
  assign do_ack  = ack && irq_out;
  assign do_eos  = eos && isr_any;
  assign win_hot = NSRC'(1) << win_idx;
  assign top_hot = NSRC'(1) << top_idx;

  always_comb begin
    req_n = req_q | irq_lines;
    isr_n = isr_q;
    lp_n  = lp_q;
    vec_n = vec_q;
    if (do_eos) begin
      isr_n = isr_n & ~top_hot;
      if (scheme_q == SCHEME_ROTATE) lp_n = top_idx;
    end
    if (do_ack) begin
      req_n = (req_q & ~win_hot) | irq_lines;
      isr_n = isr_n | win_hot;
      vec_n = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      isr_q <= '0;
      lp_q  <= IDW'(NSRC - 1);
      vec_q <= '0;
    end else begin
      req_q <= req_n;
      if (do_ack || do_eos) isr_q <= isr_n;
      if (do_eos) lp_q <= lp_n;
      if (do_ack) vec_q <= vec_n;
    end
  end

  assign vec_out = vec_q;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NSRC = 8,
  localparam int IDW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_sel,
  input logic [NSRC-1:0] cfg_wdata,
  input logic            ack,
  input logic            eos,
  input logic            irq_out,
  input logic [IDW-1:0]  vec_out,
  input logic [NSRC-1:0] req_q,
  input logic [NSRC-1:0] isr_q,
  input logic [NSRC-1:0] mask_q
);
  // R6
  irq_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(req_q & ~mask_q)));

  // R4
  ack_sets_one_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !eos) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  // R10
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out && !eos) |=> ($stable(isr_q) && $stable(vec_out)));

  // R9
  eos_empty_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !ack && (isr_q == '0)) |=> (isr_q == '0));

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (mask_q == $past(cfg_wdata)));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .ack(ack), .eos(eos), .irq_out(irq_out),
  .vec_out(vec_out), .req_q(req_q), .isr_q(isr_q), .mask_q(mask_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       ack = 1'b0, eos = 1'b0;
  logic       irq_out;
  logic [2:0] vec_out;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // bench model state
  logic [7:0] m_req = '0, m_isr = '0, m_mask = '0;
  bit         m_rot = 1'b0;
  int         m_lp = 7;
  int         m_vec = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ack(ack), .eos(eos),
    .irq_out(irq_out), .vec_out(vec_out)
  );

  always #10 clk = ~clk;

  function automatic int m_rank(int src);
    if (!m_rot) return src;
    return ((src - (m_lp + 1)) % 8 + 8) % 8;
  endfunction

  function automatic int m_best(logic [7:0] v);
    int b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || m_rank(i) < m_rank(b))) b = i;
    return b;
  endfunction

  function automatic bit m_irq();
    int w = m_best(m_req & ~m_mask);
    int t = m_best(m_isr);
    return (w >= 0) && (t < 0 || m_rank(w) < m_rank(t));
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at edge, compare at next negedge
  task automatic step(logic [7:0] lines, bit we, bit sel, logic [7:0] wd,
                      bit a, bit e, string tag);
    bit   irq_pre, do_a, do_e;
    int   w, t;
    irq_lines = lines; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    ack = a; eos = e;
    irq_pre = m_irq();
    w = m_best(m_req & ~m_mask);
    t = m_best(m_isr);
    do_a = a && irq_pre;
    do_e = e && (t >= 0);
    @(posedge clk);
    if (do_e) begin
      m_isr[t] = 1'b0;
      if (m_rot) m_lp = t;
    end
    if (do_a) begin
      m_req[w] = 1'b0;
      m_isr[w] = 1'b1;
      m_vec = w;
    end
    m_req = m_req | lines;
    if (we) begin
      if (sel) m_mask = wd;
      else     m_rot = wd[0];
    end
    @(negedge clk);
    irq_lines = '0; cfg_we = 1'b0; ack = 1'b0; eos = 1'b0;
    check({tag, " irq"}, int'(irq_out), int'(m_irq()));
    check({tag, " vec"}, int'(vec_out), m_vec);
  endtask

  task automatic idle(string tag);
    step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(irq_out), 0);
    check("R1 vec", int'(vec_out), 0);

    // R2 / R3 nested order
    step(8'b0010_0100, 0, 0, 0, 0, 0, "R2");
    check("R2 irq raised", int'(irq_out), 1);
    step(8'h00, 0, 0, 0, 1, 0, "R3");
    check("R3 lowest number wins", int'(vec_out), 2);
    // R5 lower source 5 pending while 2 in service
    check("R5 no preempt", int'(irq_out), 0);
    step(8'b0000_0010, 0, 0, 0, 0, 0, "R5");
    check("R5 higher preempts", int'(irq_out), 1);
    step(8'h00, 0, 0, 0, 1, 0, "R4");
    check("R4 vec", int'(vec_out), 1);
    check("R4 pending cleared", int'(irq_out), 0);
    // R9 retire highest in-service first
    step(8'h00, 0, 0, 0, 0, 1, "R9");
    check("R9 after first eos", int'(irq_out), 0);
    step(8'h00, 0, 0, 0, 0, 1, "R9");
    check("R9 after second eos", int'(irq_out), 1);
    step(8'h00, 0, 0, 0, 1, 0, "R4");
    check("R4 vec 5", int'(vec_out), 5);
    step(8'h00, 0, 0, 0, 0, 1, "R9");
    step(8'h00, 0, 0, 0, 0, 1, "R9 empty");
    check("R9 empty eos", int'(irq_out), 0);

    // R6 mask
    step(8'h00, 1, 1, 8'h01, 0, 0, "R6");
    step(8'h01, 0, 0, 0, 0, 0, "R6");
    check("R6 masked", int'(irq_out), 0);
    step(8'h00, 1, 1, 8'h00, 0, 0, "R6");
    check("R6 unmasked pending", int'(irq_out), 1);
    step(8'h00, 0, 0, 0, 1, 0, "R6");
    check("R6 vec", int'(vec_out), 0);
    step(8'h00, 0, 0, 0, 0, 1, "R6");

    // R10 idle ack
    step(8'h08, 0, 0, 0, 0, 0, "R10");
    step(8'h00, 0, 0, 0, 1, 0, "R10");
    step(8'h00, 0, 0, 0, 0, 1, "R10");
    step(8'h00, 0, 0, 0, 1, 0, "R10");
    check("R10 vec kept", int'(vec_out), 3);
    check("R10 irq low", int'(irq_out), 0);

    // R7 / R8 rotation
    step(8'h00, 1, 0, 8'h01, 0, 0, "R7");
    step(8'b0000_1001, 0, 0, 0, 0, 0, "R7");
    step(8'h00, 0, 0, 0, 1, 0, "R7");
    check("R7 rotate initial order", int'(vec_out), 0);
    step(8'h00, 0, 0, 0, 0, 1, "R8");
    step(8'h01, 0, 0, 0, 0, 0, "R8");
    step(8'h00, 0, 0, 0, 1, 0, "R8");
    check("R8 retired 0 ranks last", int'(vec_out), 3);
    step(8'h00, 0, 0, 0, 0, 1, "R8");
    step(8'h04, 0, 0, 0, 0, 0, "R8");
    step(8'h00, 0, 0, 0, 1, 0, "R8");
    check("R8 wrap after 3", int'(vec_out), 0);
    step(8'h00, 0, 0, 0, 0, 1, "R8");
    step(8'h00, 0, 0, 0, 1, 0, "R8");
    check("R8 last one", int'(vec_out), 2);
    step(8'h00, 0, 0, 0, 0, 1, "R8");

    // random traffic, both schemes
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] l;
      bit we, sel, a, e;
      l   = 8'($urandom & $urandom & $urandom);
      we  = ($urandom % 16) == 0;
      sel = $urandom % 2;
      a   = ($urandom % 3) == 0;
      e   = ($urandom % 4) == 0;
      step(l, we, sel, 8'($urandom & $urandom), a, e, "R5/R8 random");
    end
    idle("R2 tail");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule